// File: doc/BRIEF.md
# Majority-Vote Track Pattern Bank

This block holds a bank of pre-computed track patterns and decides, once per event, which of them the hits of that event support. Each pattern has one stored ternary word per detector layer. During an event every layer has its own hit bus. A hit on a layer is compared at once against the word that every pattern stores for that layer. A stored word that matches raises a sticky per-slot flag. Words the bank does not know leave no trace.

When the event is closed, each pattern counts its raised flags against a runtime threshold. The threshold lets a pattern be accepted with one or two layers missing. The addresses of all accepted patterns are then streamed out one per cycle, lowest address first, and a done pulse ends the burst. While the burst runs the bank takes no new hits, which keeps the flag state stable. Between events the flags are wiped by an explicit clear.

Top module: `majority_pattern_bank`

## Requirements
- R1: After reset, out_valid and out_done are low and hit_ready is high. The threshold is 6 and every layer flag is clear. Every slot holds the word 0 with all care bits set, so an unwritten slot matches only the hit word 0.
- R2: A write with wr_en stores wr_value and wr_care into the slot chosen by wr_pat and wr_layer, replacing what was there. A care bit of 1 makes that bit position compared. A care bit of 0 makes it a don't-care.
- R3: When hit_valid[l] is high and hit_ready is high, every pattern whose layer-l slot matches hit_word[l*15 +: 15] sets that slot's flag. A flag stays set through later non-matching hits until a clear.
- R4: In a readout, a pattern's address is reported if and only if the number of its set layer flags is at least the threshold.
- R5: With thr_wr_en high, the threshold takes thr_value when thr_value is 6, 7 or 8. Any other value leaves the threshold unchanged.
- R6: Suppose end_event is high with hit_ready high at clock edge E0. From edge E1 on, one reported address is presented per cycle with out_valid high, with no gaps and in strictly ascending address order.
- R7: out_done is a one-cycle pulse that starts at the edge after the last reported address, or at E1 when nothing is reported. out_valid is low during that cycle.
- R8: hit_ready is low from E0 until the out_done pulse. While hit_ready is low, hit_valid, clear_event and end_event have no effect.
- R9: clear_event with hit_ready high clears every layer flag at the next edge. A hit accepted in that same cycle is lost, because the clear wins.
- R10: A hit accepted in the same cycle as the end_event that starts a readout counts toward that readout.
- R11: A readout does not clear the flags. A second end_event with no clear in between reports the same set of addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write one slot |
| wr_pat | input | 6 | Pattern address of the write |
| wr_layer | input | 3 | Layer index of the write |
| wr_value | input | 15 | Stored word |
| wr_care | input | 15 | Care mask, 1 = bit compared |
| thr_wr_en | input | 1 | Load the majority threshold |
| thr_value | input | 4 | New threshold, accepted if 6 to 8 |
| hit_valid | input | 8 | One strobe per layer bus |
| hit_word | input | 120 | Layer l hit word at bits l*15 +: 15 |
| hit_ready | output | 1 | Bank accepts hits, clear and end_event |
| clear_event | input | 1 | Wipe all layer flags |
| end_event | input | 1 | Close the event and start readout |
| out_valid | output | 1 | out_addr holds a reported pattern |
| out_addr | output | 6 | Reported pattern address |
| out_done | output | 1 | One-cycle end-of-readout pulse |

## Verification
Two operations can meet in one cycle: accepting a hit, and either the clear or the end of the event. The bench drives a layer hit in the very cycle of end_event. It then checks that the pattern appears in the readout when it needed that hit to reach the threshold. It also drives a hit together with clear_event, then follows with exactly enough hits that the pattern would pass only if the same-cycle hit had survived. The pattern must not be reported. A third case sends hits, a clear and a second end_event while the readout is still running. It then checks that the burst completes unchanged and that a fresh readout shows the untouched flag state.

// File: rtl/bank_pkg.sv
// Shared types for the majority pattern bank.
package bank_pkg;

    // Readout sequencer state: idle (taking hits) or scanning out matches.
    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_SCAN = 1'b1
    } rd_state_e;

endpackage

// File: rtl/ternary_slot.sv
// One layer slot of one pattern: a stored ternary word and a sticky match flag.
// Assumes hit_en is already qualified by the bank's ready state and that
// flag_clr has priority over a match arriving in the same cycle.
module ternary_slot #(
    parameter int WORD_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_value,
    input  logic [WORD_W-1:0] wr_care,
    input  logic              hit_en,
    input  logic [WORD_W-1:0] hit_word,
    input  logic              flag_clr,
    output logic              flag
);

    logic [WORD_W-1:0] value_q;
    logic [WORD_W-1:0] care_q;
    logic              match;

    // Store the ternary word on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value_q <= '0;
            care_q  <= '1;
        end else if (wr_en) begin
            value_q <= wr_value;
            care_q  <= wr_care;
        end
    end

    // Compare only the bit positions that are cared for.
    always_comb begin
        match = (((hit_word ^ value_q) & care_q) == '0);
    end

    // Sticky flag: set on a qualified match, cleared by the event clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (flag_clr) begin
            flag <= 1'b0;
        end else if (hit_en && match) begin
            flag <= 1'b1;
        end
    end

endmodule

// File: rtl/layer_vote.sv
// Majority vote for one pattern: counts set layer flags and compares
// the count with the runtime threshold. Purely combinational.
module layer_vote #(
    parameter int N_LAYER = 8,
    localparam int CNT_W  = $clog2(N_LAYER + 1)
) (
    input  logic [N_LAYER-1:0] flags,
    input  logic [CNT_W-1:0]   thr,
    output logic               pass
);

    logic [CNT_W-1:0] cnt;

    // Population count of the layer flags, then threshold compare.
    always_comb begin
        cnt = '0;
        for (int l = 0; l < N_LAYER; l++) begin
            cnt = cnt + CNT_W'(flags[l]);
        end
        pass = (cnt >= thr);
    end

endmodule

// File: rtl/lowest_first_tree.sv
// Priority tree: finds the lowest set index of a request vector.
// Assumes N is a power of two and at least 2. Nodes are held heap-style:
// leaves at N-1..2N-2, node k has children 2k+1 (lower) and 2k+2 (higher).
module lowest_first_tree #(
    parameter int N       = 64,
    localparam int IDX_W  = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    logic             v_n  [2*N-1];
    logic [IDX_W-1:0] id_n [2*N-1];

    // Build leaves, then reduce pairwise towards the root, left side winning.
    always_comb begin
        for (int j = 0; j < N; j++) begin
            v_n[N-1+j]  = req[j];
            id_n[N-1+j] = IDX_W'(j);
        end
        for (int k = N - 2; k >= 0; k--) begin
            v_n[k]  = v_n[2*k+1] | v_n[2*k+2];
            id_n[k] = v_n[2*k+1] ? id_n[2*k+1] : id_n[2*k+2];
        end
    end

    assign any = v_n[0];
    assign idx = id_n[0];

endmodule

// File: rtl/majority_pattern_bank.sv
// Bank of N_PAT track patterns with N_LAYER ternary layer slots each.
// Hits set sticky per-slot flags; on end_event every pattern whose flag
// count reaches the threshold is streamed out lowest address first, then
// out_done pulses. Hits, clear and end_event are only taken while idle.
// Assumes N_PAT is a power of two and MAX_MISS < N_LAYER.
module majority_pattern_bank #(
    parameter int N_PAT    = 64,
    parameter int N_LAYER  = 8,
    parameter int WORD_W   = 15,
    parameter int MAX_MISS = 2,
    localparam int PAT_W   = $clog2(N_PAT),
    localparam int LAY_W   = $clog2(N_LAYER),
    localparam int CNT_W   = $clog2(N_LAYER + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [PAT_W-1:0]           wr_pat,
    input  logic [LAY_W-1:0]           wr_layer,
    input  logic [WORD_W-1:0]          wr_value,
    input  logic [WORD_W-1:0]          wr_care,
    input  logic                       thr_wr_en,
    input  logic [CNT_W-1:0]           thr_value,
    input  logic [N_LAYER-1:0]         hit_valid,
    input  logic [N_LAYER*WORD_W-1:0]  hit_word,
    output logic                       hit_ready,
    input  logic                       clear_event,
    input  logic                       end_event,
    output logic                       out_valid,
    output logic [PAT_W-1:0]           out_addr,
    output logic                       out_done
);
    import bank_pkg::*;

    localparam logic [CNT_W-1:0] THR_LO = CNT_W'(N_LAYER - MAX_MISS);
    localparam logic [CNT_W-1:0] THR_HI = CNT_W'(N_LAYER);

    rd_state_e                  state_q;
    logic [CNT_W-1:0]           thr_q;
    logic [N_PAT-1:0]           sent_q;
    logic [N_PAT*N_LAYER-1:0]   flag_all;
    logic [N_PAT-1:0]           pass_vec;
    logic [N_PAT-1:0]           pending;
    logic                       pend_any;
    logic [PAT_W-1:0]           pend_idx;
    logic [N_LAYER-1:0]         hit_en;
    logic                       clr_en;

    // Inputs from the event side are gated by the ready state.
    always_comb begin
        hit_ready = (state_q == RD_IDLE);
        hit_en    = hit_valid & {N_LAYER{hit_ready}};
        clr_en    = clear_event && hit_ready;
    end

    // Slot array and one majority vote per pattern.
    for (genvar p = 0; p < N_PAT; p++) begin : g_pat
        for (genvar l = 0; l < N_LAYER; l++) begin : g_lay
            ternary_slot #(.WORD_W(WORD_W)) u_slot (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_en    (wr_en && (wr_pat == PAT_W'(p)) && (wr_layer == LAY_W'(l))),
                .wr_value (wr_value),
                .wr_care  (wr_care),
                .hit_en   (hit_en[l]),
                .hit_word (hit_word[l*WORD_W +: WORD_W]),
                .flag_clr (clr_en),
                .flag     (flag_all[p*N_LAYER + l])
            );
        end
        layer_vote #(.N_LAYER(N_LAYER)) u_vote (
            .flags (flag_all[p*N_LAYER +: N_LAYER]),
            .thr   (thr_q),
            .pass  (pass_vec[p])
        );
    end

    // Patterns that passed and have not been sent yet in this readout.
    always_comb begin
        pending = pass_vec & ~sent_q;
    end

    lowest_first_tree #(.N(N_PAT)) u_pick (
        .req (pending),
        .any (pend_any),
        .idx (pend_idx)
    );

    // Runtime threshold register, out-of-range writes dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q <= THR_LO;
        end else if (thr_wr_en && (thr_value >= THR_LO) && (thr_value <= THR_HI)) begin
            thr_q <= thr_value;
        end
    end

    // Readout sequencer: one address per cycle, mask it, then pulse done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= RD_IDLE;
            sent_q    <= '0;
            out_valid <= 1'b0;
            out_addr  <= '0;
            out_done  <= 1'b0;
        end else begin
            case (state_q)
                RD_IDLE: begin
                    out_valid <= 1'b0;
                    out_done  <= 1'b0;
                    if (end_event) begin
                        sent_q  <= '0;
                        state_q <= RD_SCAN;
                    end
                end
                RD_SCAN: begin
                    if (pend_any) begin
                        out_valid        <= 1'b1;
                        out_addr         <= pend_idx;
                        sent_q[pend_idx] <= 1'b1;
                    end else begin
                        out_valid <= 1'b0;
                        out_done  <= 1'b1;
                        state_q   <= RD_IDLE;
                    end
                end
                default: state_q <= RD_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/bank_checker.sv
// Temporal checks on the pattern bank's readout handshake and threshold.
// Bound into every instance of majority_pattern_bank.
module bank_checker #(
    parameter int N_PAT    = 64,
    parameter int N_LAYER  = 8,
    parameter int MAX_MISS = 2,
    localparam int PAT_W   = $clog2(N_PAT),
    localparam int CNT_W   = $clog2(N_LAYER + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hit_ready,
    input logic             end_event,
    input logic             out_valid,
    input logic [PAT_W-1:0] out_addr,
    input logic             out_done,
    input logic [CNT_W-1:0] thr_q
);

    localparam logic [CNT_W-1:0] THR_LO = CNT_W'(N_LAYER - MAX_MISS);
    localparam logic [CNT_W-1:0] THR_HI = CNT_W'(N_LAYER);

    assert_valid_done_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_done));

    assert_done_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |=> !out_done);

    assert_no_ready_in_burst_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !hit_ready);

    assert_start_drops_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (end_event && hit_ready) |=> !hit_ready);

    assert_done_restores_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> hit_ready);

    assert_addr_ascending_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> (out_addr > $past(out_addr)));

    assert_thr_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_q >= THR_LO) && (thr_q <= THR_HI));

endmodule

bind majority_pattern_bank bank_checker #(
    .N_PAT    (N_PAT),
    .N_LAYER  (N_LAYER),
    .MAX_MISS (MAX_MISS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit_ready (hit_ready),
    .end_event (end_event),
    .out_valid (out_valid),
    .out_addr  (out_addr),
    .out_done  (out_done),
    .thr_q     (thr_q)
);

// File: tb/sim_majority_pattern_bank.sv
`timescale 1ns/1ps
module sim_majority_pattern_bank;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         wr_en;
    logic [5:0]   wr_pat;
    logic [2:0]   wr_layer;
    logic [14:0]  wr_value;
    logic [14:0]  wr_care;
    logic         thr_wr_en;
    logic [3:0]   thr_value;
    logic [7:0]   hit_valid;
    logic [119:0] hit_word;
    logic         hit_ready;
    logic         clear_event;
    logic         end_event;
    logic         out_valid;
    logic [5:0]   out_addr;
    logic         out_done;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;

    always #2 clk = ~clk;

    majority_pattern_bank u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_pat(wr_pat), .wr_layer(wr_layer),
        .wr_value(wr_value), .wr_care(wr_care), .thr_wr_en(thr_wr_en), .thr_value(thr_value),
        .hit_valid(hit_valid), .hit_word(hit_word), .hit_ready(hit_ready),
        .clear_event(clear_event), .end_event(end_event), .out_valid(out_valid),
        .out_addr(out_addr), .out_done(out_done)
    );

    // Patterns used by the vectors; masks packed {m3, m17, m40, m63}.
    localparam int PATS [4] = '{3, 17, 40, 63};
    localparam logic [35:0] VEC [8] = '{
        {4'd6, 8'hFF, 8'h7F, 8'h3F, 8'h1F},
        {4'd7, 8'hFF, 8'h7F, 8'h3F, 8'h1F},
        {4'd8, 8'hFF, 8'h7F, 8'h3F, 8'h1F},
        {4'd6, 8'h00, 8'h00, 8'h00, 8'h00},
        {4'd6, 8'hFC, 8'hF3, 8'h0F, 8'hFE},
        {4'd8, 8'hFF, 8'hFF, 8'hFF, 8'hFF},
        {4'd7, 8'h7F, 8'h00, 8'hFE, 8'hBF},
        {4'd6, 8'h3F, 8'hC0, 8'hFF, 8'h01}
    };

    function automatic logic [14:0] pword(int p, int l);
        return 15'h4000 | 15'(p << 3) | 15'(l);
    endfunction

    // Hit bus for pattern p; pattern 63 layer 0 gets bit 1 flipped (don't-care bit).
    function automatic logic [119:0] hit_bus(int p);
        logic [119:0] b;
        b = '0;
        for (int l = 0; l < 8; l++) begin
            logic [14:0] w;
            w = pword(p, l);
            if (p == 63 && l == 0) w = w ^ 15'h0002;
            b[l*15 +: 15] = w;
        end
        return b;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic write_slot(input int p, input int l, input logic [14:0] v, input logic [14:0] c);
        @(negedge clk);
        wr_en = 1'b1; wr_pat = 6'(p); wr_layer = 3'(l); wr_value = v; wr_care = c;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_thr(input logic [3:0] v);
        @(negedge clk);
        thr_wr_en = 1'b1; thr_value = v;
        @(negedge clk);
        thr_wr_en = 1'b0;
    endtask

    task automatic send_hits(input int p, input logic [7:0] mask);
        if (mask != 8'h00) begin
            @(negedge clk);
            hit_valid = mask; hit_word = hit_bus(p);
            @(negedge clk);
            hit_valid = 8'h00;
        end
    endtask

    task automatic clear_flags();
        @(negedge clk);
        clear_event = 1'b1;
        @(negedge clk);
        clear_event = 1'b0;
    endtask

    // Close the event and collect the burst; optionally disturb during readout.
    task automatic do_event(input logic [63:0] exp, input string tag, input bit disturb,
                            input int end_pat, input logic [7:0] end_mask);
        logic [63:0] got;
        int done_at;
        int last;
        bit ok;
        @(negedge clk);
        end_event = 1'b1;
        if (end_mask != 8'h00) begin
            hit_valid = end_mask; hit_word = hit_bus(end_pat);
        end
        @(negedge clk);
        end_event = 1'b0; hit_valid = 8'h00;
        chk(hit_ready == 1'b0, "R8", {tag, " ready low in readout"}, 64'(hit_ready), 64'd0);
        if (disturb) begin
            hit_valid = 8'h20; hit_word = hit_bus(40); clear_event = 1'b1; end_event = 1'b1;
        end
        got = '0; done_at = 0; last = -1; ok = 1'b1;
        for (int k = 1; k <= 70; k++) begin
            @(negedge clk);
            hit_valid = 8'h00; clear_event = 1'b0; end_event = 1'b0;
            if (out_done) begin
                done_at = k;
                if (out_valid) ok = 1'b0;
                break;
            end
            if (out_valid) begin
                got[out_addr] = 1'b1;
                if (int'(out_addr) <= last) ok = 1'b0;
                last = int'(out_addr);
            end else begin
                ok = 1'b0;
            end
        end
        chk(got == exp, "R4", {tag, " reported set"}, got, exp);
        chk(done_at == $countones(exp) + 1, "R7", {tag, " done cycle"},
            64'(done_at), 64'($countones(exp) + 1));
        chk(ok, "R6", {tag, " ascending gapless burst"}, 64'(ok), 64'd1);
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=%0d expected<%0d", cyc, 100000);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [63:0] e;
        rst_n = 1'b0; wr_en = 1'b0; wr_pat = '0; wr_layer = '0; wr_value = '0; wr_care = '0;
        thr_wr_en = 1'b0; thr_value = '0; hit_valid = '0; hit_word = '0;
        clear_event = 1'b0; end_event = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        chk(out_valid == 1'b0, "R1", "out_valid after reset", 64'(out_valid), 64'd0);
        chk(out_done == 1'b0, "R1", "out_done after reset", 64'(out_done), 64'd0);
        chk(hit_ready == 1'b1, "R1", "hit_ready after reset", 64'(hit_ready), 64'd1);

        for (int i = 0; i < 4; i++)
            for (int l = 0; l < 8; l++)
                write_slot(PATS[i], l, pword(PATS[i], l),
                           (PATS[i] == 63 && l == 0) ? 15'h7FFC : 15'h7FFF);

        // R1: default threshold 6, no clear needed after reset
        send_hits(3, 8'h3F); send_hits(17, 8'h1F);
        e = '0; e[3] = 1'b1;
        do_event(e, "R1 default thr", 1'b0, 0, 8'h00);

        // R5: 5 and 9 are rejected
        set_thr(4'd5); set_thr(4'd9);
        clear_flags(); send_hits(3, 8'h3F); send_hits(17, 8'h1F);
        do_event(e, "R5 bad thr ignored", 1'b0, 0, 8'h00);

        // Table walk: thresholds and layer masks, expected from the vote rule (R2 R4 R9)
        for (int v = 0; v < 8; v++) begin
            logic [3:0] th;
            th = VEC[v][35:32];
            set_thr(th);
            clear_flags();
            e = '0;
            for (int i = 0; i < 4; i++) begin
                logic [7:0] m;
                m = VEC[v][31 - 8*i -: 8];
                send_hits(PATS[i], m);
                if ($countones(m) >= int'(th)) e[PATS[i]] = 1'b1;
            end
            do_event(e, $sformatf("vector %0d", v), 1'b0, 0, 8'h00);
        end

        set_thr(4'd6);
        // R10: sixth layer arrives in the end_event cycle
        clear_flags(); send_hits(40, 8'h1F);
        e = '0; e[40] = 1'b1;
        do_event(e, "R10 hit with end", 1'b0, 40, 8'h20);

        // R8: hit, clear and end during readout are ignored; R11: flags survive readout
        clear_flags(); send_hits(17, 8'h3F); send_hits(40, 8'h1F);
        e = '0; e[17] = 1'b1;
        do_event(e, "R8 disturbed burst", 1'b1, 0, 8'h00);
        do_event(e, "R11 repeat readout", 1'b0, 0, 8'h00);

        // R9: clear and hit in one cycle, clear wins
        clear_flags();
        @(negedge clk);
        clear_event = 1'b1; hit_valid = 8'h01; hit_word = hit_bus(3);
        @(negedge clk);
        clear_event = 1'b0; hit_valid = 8'h00;
        send_hits(3, 8'h3E);
        do_event(64'd0, "R9 clear beats hit", 1'b0, 0, 8'h00);

        // R3: flags stay set through non-matching hits
        clear_flags(); send_hits(3, 8'h0F); send_hits(0, 8'h0F); send_hits(3, 8'h30);
        e = '0; e[3] = 1'b1;
        do_event(e, "R3 sticky", 1'b0, 0, 8'h00);

        // R2: rewrite replaces the old word
        set_thr(4'd8);
        write_slot(17, 7, 15'h1234, 15'h7FFF);
        clear_flags(); send_hits(17, 8'hFF);
        do_event(64'd0, "R2 old word gone", 1'b0, 0, 8'h00);
        @(negedge clk);
        hit_valid = 8'h80; hit_word = '0; hit_word[7*15 +: 15] = 15'h1234;
        @(negedge clk);
        hit_valid = 8'h00;
        e = '0; e[17] = 1'b1;
        do_event(e, "R2 new word", 1'b0, 0, 8'h00);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule